// File: doc/BRIEF.md
# Serial signed-digit to BCD product converter

This block sits at the tail of an iterative decimal multiplier. Every iteration hands it the lowest digit of the redundant intermediate product. That digit is a signed value from -9 to +9. The block turns it into one ordinary BCD digit of the final product in the same iteration. The whole carry chain is held in a single registered borrow bit, so no full-width carry-propagate conversion is needed.

The digit chosen in each cycle follows a four-way choice on two conditions: the sign of the incoming digit and the borrow left by the digit before it. The four outcomes are:
- pass the digit through unchanged;
- pass it and subtract one;
- take the ten's complement of its magnitude;
- take the nine's complement of its magnitude.

A stream begins with `start_i` and ends with `last_i`. After the last digit, the block emits a fixed number of extension digits and reports the sign. The result is read as a ten's-complement decimal number: the extension digits are 9 when the result is negative and 0 when it is positive.

Top module: `sdbcd_serial_conv`

## Requirements
- R1: Each input digit accepted (`valid_i` high while idle with `start_i`, or while a stream runs) produces exactly one output digit, with `valid_o` high and `ext_o` low, in the cycle after the clock edge that accepts it.
- R2: When the digit is >= 0 and no borrow is pending, the output digit equals the input digit, and no borrow is left.
- R3: When the digit is >= 0 and a borrow is pending, the output is the digit minus one. A zero digit with a pending borrow gives 9 and keeps the borrow pending.
- R4: When the digit is negative, the output is 10-|d| if no borrow is pending and 9-|d| if one is pending. In both cases a borrow is left pending.
- R5: A digit accepted with `start_i` high ignores any borrow left over from an earlier stream.
- R6: After the digit marked by `last_i`, the block emits EXT_DIGITS further digits, one per cycle, each with `valid_o` and `ext_o` high. Each is 9 if a borrow is pending and 0 otherwise.
- R7: `done_o` is high for one cycle, together with the final extension digit. `neg_o` then equals the final borrow and holds until the next stream starts.
- R8: While idle, `valid_i` without `start_i` produces no output digit.
- R9: `valid_o` is high only in cycles where a digit is emitted. Every emitted digit is in 0..9.
- R10: Take the n stream digits d_i, where d_0 comes first. Their outputs, followed by the extension digits, read least significant first, form sum(d_i*10^i) modulo 10^(n+EXT_DIGITS).
- R11: `digit_i` is a 5-bit two's-complement value. Output digits are 4-bit BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | First digit of a stream, qualified by valid_i |
| valid_i | input | 1 | Input digit present |
| last_i | input | 1 | Final digit of the stream, qualified by valid_i |
| digit_i | input | 5 | Signed digit, two's complement, -9..+9 |
| bcd_o | output | 4 | Emitted BCD digit |
| valid_o | output | 1 | bcd_o holds a digit this cycle |
| ext_o | output | 1 | Emitted digit is a sign-extension digit |
| done_o | output | 1 | Final digit of the result, sign is valid |
| neg_o | output | 1 | Result is negative (ten's-complement form) |

## Verification
The assertions assume four things about the inputs:
- `digit_i` stays within -9..+9;
- `last_i` is only raised together with `valid_i`;
- `valid_i` is held low while the extension digits flush;
- a new stream only begins once the block is idle.

The directed tasks meet these by driving one stream at a time. Each task waits for `done_o` before the next stream starts. The random streams draw digits only from -9..+9.

// File: rtl/sdbcd_pkg.sv
package sdbcd_pkg;
  localparam int SD_W  = 5;
  localparam int BCD_W = 4;

  typedef enum logic [1:0] {OP_PASS, OP_DEC, OP_NEG, OP_NEG_DEC} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH} st_e;

  typedef struct packed {
    logic [BCD_W-1:0] bcd;
    logic             borrow;
  } conv_t;
endpackage

// File: rtl/sdbcd_case_sel.sv
module sdbcd_case_sel
  import sdbcd_pkg::*;
(
  input  logic [SD_W-1:0] digit_i,
  input  logic            borrow_i,
  output op_e             op_o
);
  logic neg;
  assign neg = digit_i[SD_W-1];

  always_comb begin
    unique case ({neg, borrow_i})
      2'b00:   op_o = OP_PASS;
      2'b01:   op_o = OP_DEC;
      2'b10:   op_o = OP_NEG;
      default: op_o = OP_NEG_DEC;
    endcase
  end
endmodule

// File: rtl/sdbcd_digit_conv.sv
module sdbcd_digit_conv
  import sdbcd_pkg::*;
(
  input  logic [SD_W-1:0] digit_i,
  input  op_e             op_i,
  output conv_t           res_o
);
  logic [SD_W-1:0] mag;
  logic [SD_W-1:0] tmp;

  assign mag = digit_i[SD_W-1] ? (~digit_i + SD_W'(1)) : digit_i;

  always_comb begin
    tmp        = '0;
    res_o.bcd  = '0;
    res_o.borrow = 1'b0;
    unique case (op_i)
      OP_PASS: begin
        res_o.bcd    = digit_i[BCD_W-1:0];
        res_o.borrow = 1'b0;
      end
      OP_DEC: begin
        if (digit_i == '0) begin
          res_o.bcd    = BCD_W'(9);
          res_o.borrow = 1'b1;
        end else begin
          tmp          = digit_i - SD_W'(1);
          res_o.bcd    = tmp[BCD_W-1:0];
          res_o.borrow = 1'b0;
        end
      end
      OP_NEG: begin
        tmp          = SD_W'(10) - mag;
        res_o.bcd    = tmp[BCD_W-1:0];
        res_o.borrow = 1'b1;
      end
      default: begin
        tmp          = SD_W'(9) - mag;
        res_o.bcd    = tmp[BCD_W-1:0];
        res_o.borrow = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sdbcd_flush_ctrl.sv
module sdbcd_flush_ctrl #(
  parameter int EXT_DIGITS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CNT_W = (EXT_DIGITS > 1) ? $clog2(EXT_DIGITS) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(EXT_DIGITS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_END);
endmodule

// File: rtl/sdbcd_serial_conv.sv
module sdbcd_serial_conv
  import sdbcd_pkg::*;
#(
  parameter int EXT_DIGITS = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            valid_i,
  input  logic            last_i,
  input  logic [SD_W-1:0] digit_i,
  output logic [BCD_W-1:0] bcd_o,
  output logic            valid_o,
  output logic            ext_o,
  output logic            done_o,
  output logic            neg_o
);
  st_e   st_q;
  logic  borrow_q;
  logic  borrow_in;
  logic  take;
  logic  in_run;
  logic  in_flush;
  logic  ext_last;
  op_e   op;
  conv_t conv;

  logic [BCD_W-1:0] bcd_q;
  logic valid_q, ext_q, done_q, neg_q;

  assign in_run    = (st_q == ST_RUN);
  assign in_flush  = (st_q == ST_FLUSH);
  assign take      = valid_i && !in_flush && (start_i || in_run);
  assign borrow_in = start_i ? 1'b0 : borrow_q;

  sdbcd_case_sel u_sel (
    .digit_i  (digit_i),
    .borrow_i (borrow_in),
    .op_o     (op)
  );

  sdbcd_digit_conv u_conv (
    .digit_i (digit_i),
    .op_i    (op),
    .res_o   (conv)
  );

  sdbcd_flush_ctrl #(.EXT_DIGITS(EXT_DIGITS)) u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (take),
    .step_i (in_flush),
    .last_o (ext_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      borrow_q <= 1'b0;
      bcd_q    <= '0;
      valid_q  <= 1'b0;
      ext_q    <= 1'b0;
      done_q   <= 1'b0;
      neg_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ext_q   <= 1'b0;
      done_q  <= 1'b0;
      if (in_flush) begin
        bcd_q   <= borrow_q ? BCD_W'(9) : '0;
        valid_q <= 1'b1;
        ext_q   <= 1'b1;
        if (ext_last) begin
          done_q <= 1'b1;
          neg_q  <= borrow_q;
          st_q   <= ST_IDLE;
        end
      end else if (take) begin
        bcd_q    <= conv.bcd;
        borrow_q <= conv.borrow;
        valid_q  <= 1'b1;
        if (start_i) neg_q <= 1'b0;
        st_q <= last_i ? ST_FLUSH : ST_RUN;
      end
    end
  end

  assign bcd_o   = bcd_q;
  assign valid_o = valid_q;
  assign ext_o   = ext_q;
  assign done_o  = done_q;
  assign neg_o   = neg_q;
endmodule

// File: rtl/sdbcd_serial_conv_chk.sv
module sdbcd_serial_conv_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       valid_i,
  input logic [4:0] digit_i,
  input logic [3:0] bcd_o,
  input logic       valid_o,
  input logic       ext_o,
  input logic       done_o,
  input logic       neg_o,
  input logic       in_run,
  input logic       in_flush
);
  a_r9_bcd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (bcd_o <= 4'd9));

  a_r6_ext_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ext_o) |-> (bcd_o == 4'd0 || bcd_o == 4'd9));

  a_r7_done_on_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (valid_o && ext_o));

  a_r7_neg_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (neg_o == (bcd_o == 4'd9)));

  a_r1_one_per_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_flush && (start_i || in_run)) |=> (valid_o && !ext_o));

  a_r5_start_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i && !in_flush && !digit_i[4]) |=> (bcd_o == $past(digit_i[3:0])));

  a_r4_start_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i && !in_flush && digit_i[4]) |=> (bcd_o == 4'(5'd10 + $past(digit_i))));

  a_r8_idle_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !start_i && !in_run && !in_flush) |=> !valid_o);
endmodule

bind sdbcd_serial_conv sdbcd_serial_conv_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .valid_i  (valid_i),
  .digit_i  (digit_i),
  .bcd_o    (bcd_o),
  .valid_o  (valid_o),
  .ext_o    (ext_o),
  .done_o   (done_o),
  .neg_o    (neg_o),
  .in_run   (in_run),
  .in_flush (in_flush)
);

// File: tb/sdbcd_serial_conv_test.sv
module sdbcd_serial_conv_test;
  localparam int EXT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, last = 1'b0;
  logic [4:0] digit = '0;
  logic [3:0] bcd;
  logic valid_o, ext_o, done_o, neg_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [3:0] got_d [0:31];
  logic       got_e [0:31];
  int  got_n = 0;
  logic done_seen = 1'b0;
  logic neg_seen = 1'b0;

  int digs [0:15];

  always #2 clk = ~clk;

  sdbcd_serial_conv #(.EXT_DIGITS(EXT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid),
    .last_i(last), .digit_i(digit), .bcd_o(bcd), .valid_o(valid_o),
    .ext_o(ext_o), .done_o(done_o), .neg_o(neg_o)
  );

  always @(negedge clk) begin
    if (valid_o && got_n < 32) begin
      got_d[got_n] = bcd;
      got_e[got_n] = ext_o;
      got_n = got_n + 1;
    end
    if (done_o) begin
      done_seen = 1'b1;
      neg_seen  = neg_o;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint pow10(input int e);
    longint p = 1;
    for (int i = 0; i < e; i++) p = p * 10;
    return p;
  endfunction

  task automatic clear_collect();
    got_n = 0;
    done_seen = 1'b0;
    neg_seen = 1'b0;
  endtask

  task automatic run_stream(input int n, input string req);
    longint ref_v = 0;
    longint m, r;
    clear_collect();
    for (int i = 0; i < n; i++) ref_v = ref_v + longint'(digs[i]) * pow10(i);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = (i == 0);
      valid = 1'b1;
      last  = (i == n - 1);
      digit = 5'(digs[i]);
    end
    @(negedge clk);
    start = 1'b0; valid = 1'b0; last = 1'b0; digit = '0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      if (done_seen) break;
    end
    m = pow10(n + EXT);
    r = ref_v % m;
    if (r < 0) r = r + m;
    check({req, " R1 digit count"}, got_n, n + EXT);
    check("R7 done seen", done_seen, 1);
    check("R7 neg flag", neg_seen, (ref_v < 0) ? 1 : 0);
    for (int i = 0; i < n + EXT && i < got_n; i++) begin
      check({req, " R10 digit"}, got_d[i], (r / pow10(i)) % 10);
      check("R6 ext flag", got_e[i], (i >= n) ? 1 : 0);
      check("R9 bcd range", (got_d[i] <= 4'd9) ? 1 : 0, 1);
    end
  endtask

  task automatic t_reset();
    check("R9 valid_o after reset", valid_o, 0);
    check("R7 done_o after reset", done_o, 0);
    check("R7 neg_o after reset", neg_o, 0);
  endtask

  task automatic t_idle_ignore();
    clear_collect();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      valid = 1'b1; start = 1'b0; digit = 5'd3;
    end
    @(negedge clk);
    valid = 1'b0; digit = '0;
    @(negedge clk);
    @(posedge clk);
    check("R8 idle digits ignored", got_n, 0);
  endtask

  task automatic t_directed();
    digs[0] = 7;
    run_stream(1, "R2");
    digs[0] = -4;
    run_stream(1, "R4");
    digs[0] = 3;
    run_stream(1, "R5");
    digs[0] = -1; digs[1] = 0; digs[2] = 0; digs[3] = 5;
    run_stream(4, "R3");
    digs[0] = -3; digs[1] = 1;
    run_stream(2, "R3");
    digs[0] = -9; digs[1] = -9; digs[2] = 4;
    run_stream(3, "R4");
    digs[0] = 9; digs[1] = 9; digs[2] = 9;
    run_stream(3, "R2");
  endtask

  task automatic t_random();
    for (int s = 0; s < 30; s++) begin
      int n = 1 + int'($urandom_range(9));
      for (int i = 0; i < n; i++) digs[i] = int'($urandom_range(18)) - 9;
      run_stream(n, "R11");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_directed();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule